// File: doc/BRIEF.md
# Hardware Transaction Conflict Tracker

This block adds best-effort transaction support to the lines of a small direct-mapped cache in one core. While a transaction is open it records which lines have been read and which have been written. A line counts as part of the transaction when either of its bits is set. The core marks transaction boundaries with begin, end and abort strobes. The cache reports local loads and stores, evictions and demand downgrades, and remote snoops arrive from the coherence fabric.

Nesting is flattened into a single depth counter, so only the outermost end commits. The transaction aborts if any of these happens to a line in the transaction: a remote request, the eviction of a dirty copy, or a demand downgrade of a dirty copy. It also aborts on an explicit abort and on a counter overflow. After a commit or abort, every tracking bit is cleared at the same clock edge. On an abort, the block also reports the written lines so the cache can discard the speculative data. For each snoop or downgrade, a combinational response tells the cache whether it may forward data, or whether the requester must be served from memory.

Top module: `htm_conflict_tracker`

## Requirements
- R1: After reset no transaction is open. All tracking bits are clear, and commit, abort, cause and invalidate mask are zero.
- R2: A begin while idle opens a transaction (tx_active_o high after that edge). Each further begin deepens the nesting, and each end makes it shallower. An end above depth one does not commit. The end that brings the depth to zero pulses commit_o for one cycle, and tx_active_o falls at the same edge.
- R3: While a transaction is open, a load to line i sets bit i of rd_set_o and a store to line i sets bit i of wr_set_o, visible after the edge. Accesses made while idle set no bit.
- R4: While a transaction is open, a remote snoop to a line in either set aborts with cause 2 and drives fwd_ok_o low in that cycle. A snoop to any other line gives fwd_ok_o high and has no effect.
- R5: Evicting a dirty line that is in either set aborts with cause 3. A clean eviction, or an eviction of a line outside both sets, has no effect.
- R6: A demand downgrade of a dirty line in either set aborts with cause 4 and drives fwd_ok_o low in that cycle. A clean downgrade is answered with fwd_ok_o high and has no effect.
- R7: An explicit abort aborts with cause 1 at any depth. While idle it is ignored and produces no pulse.
- R8: A commit clears every bit of rd_set_o and wr_set_o at the edge where commit_o rises.
- R9: An abort clears both sets and the nesting depth at the same edge. During the single cycle of abort_o, inval_mask_o shows the write set as it was before that edge. At all other times inval_mask_o is zero.
- R10: A begin at depth 15 (the 4-bit counter maximum) aborts with cause 5.
- R11: An end while idle is ignored: there is no commit pulse and no state change.
- R12: An abort condition in the same cycle as the final end wins, and no commit occurs. When several causes coincide, the reported cause follows the priority explicit (1) > remote (2) > eviction (3) > downgrade (4) > overflow (5). While abort_o is low, abort_cause_o is zero.
- R13: A begin and an end in the same cycle leave the depth unchanged, including at depth 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_begin_i | input | 1 | Transaction begin strobe |
| tx_end_i | input | 1 | Transaction end strobe |
| tx_abort_i | input | 1 | Explicit abort strobe |
| acc_valid_i | input | 1 | Local access event |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| acc_idx_i | input | 4 | Line index of the local access |
| snp_valid_i | input | 1 | Remote read or ownership snoop |
| snp_idx_i | input | 4 | Line index of the snoop |
| evict_valid_i | input | 1 | Local eviction event |
| evict_idx_i | input | 4 | Evicted line index |
| evict_dirty_i | input | 1 | Evicted line is dirty |
| dgrade_valid_i | input | 1 | Demand downgrade request |
| dgrade_idx_i | input | 4 | Downgraded line index |
| dgrade_dirty_i | input | 1 | Downgraded line is dirty |
| tx_active_o | output | 1 | Transaction open |
| commit_o | output | 1 | One-cycle commit pulse |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_cause_o | output | 3 | Abort cause, valid with abort_o |
| fwd_ok_o | output | 1 | Snoop/downgrade may be served by forwarding |
| rd_set_o | output | 16 | Per-line read-set bits |
| wr_set_o | output | 16 | Per-line write-set bits |
| inval_mask_o | output | 16 | Lines to invalidate, valid with abort_o |

## Verification
Two situations are hard to reach from the ports. The first is the overflow abort: random begins almost never pile up fifteen levels without an abort from a snoop or an eviction. The second is a conflict landing in exactly the cycle of the outermost end. Directed sequences cover both. One pushes the depth to its maximum, tries a simultaneous begin and end there, and then issues one more begin. The other aligns a hitting snoop with the final end, and also combines an explicit abort with a snoop hit to exercise cause priority. Weighted random traffic then mixes all event kinds against a bench model of the sets and depth.

// File: rtl/htm_pkg.sv
package htm_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_EXPLICIT  = 3'd1,
    CAUSE_REMOTE    = 3'd2,
    CAUSE_EVICT     = 3'd3,
    CAUSE_DOWNGRADE = 3'd4,
    CAUSE_OVERFLOW  = 3'd5
  } abort_cause_e;
endpackage

// File: rtl/htm_line_sets.sv
module htm_line_sets #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             track_i,
  input  logic             store_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [LINES-1:0] rd_o,
  output logic [LINES-1:0] wr_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit;
    assign hit = track_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_o[g] <= 1'b0;
        wr_o[g] <= 1'b0;
      end else if (clear_i) begin
        rd_o[g] <= 1'b0;
        wr_o[g] <= 1'b0;
      end else if (hit) begin
        if (store_i) wr_o[g] <= 1'b1;
        else         rd_o[g] <= 1'b1;
      end
    end
  end

  a_r8_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (rd_o == '0 && wr_o == '0));
endmodule

// File: rtl/htm_conflict_detect.sv
module htm_conflict_detect #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             active_i,
  input  logic [LINES-1:0] rd_i,
  input  logic [LINES-1:0] wr_i,
  input  logic             snp_valid_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic             ev_valid_i,
  input  logic [IDX_W-1:0] ev_idx_i,
  input  logic             ev_dirty_i,
  input  logic             dg_valid_i,
  input  logic [IDX_W-1:0] dg_idx_i,
  input  logic             dg_dirty_i,
  output logic             snp_hit_o,
  output logic             ev_hit_o,
  output logic             dg_hit_o,
  output logic             fwd_ok_o
);
  logic [LINES-1:0] tx_line;
  assign tx_line   = rd_i | wr_i;
  assign snp_hit_o = active_i && snp_valid_i && tx_line[snp_idx_i];
  assign ev_hit_o  = active_i && ev_valid_i && ev_dirty_i && tx_line[ev_idx_i];
  assign dg_hit_o  = active_i && dg_valid_i && dg_dirty_i && tx_line[dg_idx_i];
  // forwarding refused whenever the request kills the transaction
  assign fwd_ok_o  = (snp_valid_i || dg_valid_i) && !snp_hit_o && !dg_hit_o;
endmodule

// File: rtl/htm_nest_ctrl.sv
module htm_nest_ctrl
  import htm_pkg::*;
#(
  parameter int DEPTH_W = 4,
  parameter int LINES   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             begin_i,
  input  logic             end_i,
  input  logic             xabort_i,
  input  logic             snp_hit_i,
  input  logic             ev_hit_i,
  input  logic             dg_hit_i,
  input  logic [LINES-1:0] wr_set_i,
  output logic             active_o,
  output logic             clear_o,
  output logic             commit_o,
  output logic             abort_o,
  output logic [2:0]       cause_o,
  output logic [LINES-1:0] inval_mask_o
);
  localparam logic [DEPTH_W-1:0] MAX_DEPTH = {DEPTH_W{1'b1}};
  localparam logic [DEPTH_W-1:0] ONE       = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic               overflow, abort_now, commit_now;
  abort_cause_e       cause_d, cause_q;

  assign active_o = (depth_q != '0);
  assign overflow = active_o && begin_i && !end_i && (depth_q == MAX_DEPTH);

  always_comb begin
    cause_d = CAUSE_NONE;
    if (active_o) begin
      if (xabort_i)       cause_d = CAUSE_EXPLICIT;
      else if (snp_hit_i) cause_d = CAUSE_REMOTE;
      else if (ev_hit_i)  cause_d = CAUSE_EVICT;
      else if (dg_hit_i)  cause_d = CAUSE_DOWNGRADE;
      else if (overflow)  cause_d = CAUSE_OVERFLOW;
    end
  end

  assign abort_now  = (cause_d != CAUSE_NONE);
  assign commit_now = !abort_now && end_i && !begin_i && (depth_q == ONE);
  assign clear_o    = abort_now || commit_now;

  always_comb begin
    depth_d = depth_q;
    if (abort_now)                           depth_d = '0;
    else if (begin_i && !end_i)              depth_d = depth_q + ONE;
    else if (end_i && !begin_i && active_o)  depth_d = depth_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q      <= '0;
      commit_o     <= 1'b0;
      abort_o      <= 1'b0;
      cause_q      <= CAUSE_NONE;
      inval_mask_o <= '0;
    end else begin
      depth_q      <= depth_d;
      commit_o     <= commit_now;
      abort_o      <= abort_now;
      cause_q      <= cause_d;
      inval_mask_o <= abort_now ? wr_set_i : '0;
    end
  end

  assign cause_o = cause_q;

  a_r2_commit_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> depth_q == '0);
  a_r9_abort_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> depth_q == '0);
  a_r12_no_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && abort_o));
  a_r12_cause_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> cause_o != 3'd0);
  a_r12_cause_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_o |-> cause_o == 3'd0);
  a_r4_snoop_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_i |=> abort_o);
  a_r10_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (begin_i && !end_i && depth_q == MAX_DEPTH) |=> abort_o);
  a_r11_end_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_q == '0 && end_i && !begin_i) |=> (depth_q == '0 && !commit_o));
  a_r13_begin_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (begin_i && end_i && !xabort_i && !snp_hit_i && !ev_hit_i && !dg_hit_i)
      |=> $stable(depth_q));
endmodule

// File: rtl/htm_conflict_tracker.sv
module htm_conflict_tracker #(
  parameter int LINES   = 16,
  parameter int DEPTH_W = 4,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_begin_i,
  input  logic             tx_end_i,
  input  logic             tx_abort_i,
  input  logic             acc_valid_i,
  input  logic             acc_store_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  input  logic             snp_valid_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic             evict_valid_i,
  input  logic [IDX_W-1:0] evict_idx_i,
  input  logic             evict_dirty_i,
  input  logic             dgrade_valid_i,
  input  logic [IDX_W-1:0] dgrade_idx_i,
  input  logic             dgrade_dirty_i,
  output logic             tx_active_o,
  output logic             commit_o,
  output logic             abort_o,
  output logic [2:0]       abort_cause_o,
  output logic             fwd_ok_o,
  output logic [LINES-1:0] rd_set_o,
  output logic [LINES-1:0] wr_set_o,
  output logic [LINES-1:0] inval_mask_o
);
  logic active, clear, snp_hit, ev_hit, dg_hit;

  htm_line_sets #(.LINES(LINES)) i_sets (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .track_i (active && acc_valid_i),
    .store_i (acc_store_i),
    .idx_i   (acc_idx_i),
    .rd_o    (rd_set_o),
    .wr_o    (wr_set_o)
  );

  htm_conflict_detect #(.LINES(LINES)) i_detect (
    .active_i    (active),
    .rd_i        (rd_set_o),
    .wr_i        (wr_set_o),
    .snp_valid_i (snp_valid_i),
    .snp_idx_i   (snp_idx_i),
    .ev_valid_i  (evict_valid_i),
    .ev_idx_i    (evict_idx_i),
    .ev_dirty_i  (evict_dirty_i),
    .dg_valid_i  (dgrade_valid_i),
    .dg_idx_i    (dgrade_idx_i),
    .dg_dirty_i  (dgrade_dirty_i),
    .snp_hit_o   (snp_hit),
    .ev_hit_o    (ev_hit),
    .dg_hit_o    (dg_hit),
    .fwd_ok_o    (fwd_ok_o)
  );

  htm_nest_ctrl #(.DEPTH_W(DEPTH_W), .LINES(LINES)) i_nest (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .begin_i      (tx_begin_i),
    .end_i        (tx_end_i),
    .xabort_i     (tx_abort_i),
    .snp_hit_i    (snp_hit),
    .ev_hit_i     (ev_hit),
    .dg_hit_i     (dg_hit),
    .wr_set_i     (wr_set_o),
    .active_o     (active),
    .clear_o      (clear),
    .commit_o     (commit_o),
    .abort_o      (abort_o),
    .cause_o      (abort_cause_o),
    .inval_mask_o (inval_mask_o)
  );

  assign tx_active_o = active;

  a_r3_idle_no_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_o |-> (rd_set_o == '0 && wr_set_o == '0));
  a_r8_commit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (rd_set_o == '0 && wr_set_o == '0 && !tx_active_o));
  a_r6_dg_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dgrade_valid_i && dgrade_dirty_i && tx_active_o &&
     (rd_set_o[dgrade_idx_i] || wr_set_o[dgrade_idx_i])) |-> !fwd_ok_o);
endmodule

// File: tb/test_htm_conflict_tracker.sv
`timescale 1ns/1ps
module test_htm_conflict_tracker;
  localparam int LINES = 16;
  localparam int IDX_W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_begin_i = 0, tx_end_i = 0, tx_abort_i = 0;
  logic acc_valid_i = 0, acc_store_i = 0;
  logic [IDX_W-1:0] acc_idx_i = '0, snp_idx_i = '0, evict_idx_i = '0, dgrade_idx_i = '0;
  logic snp_valid_i = 0, evict_valid_i = 0, evict_dirty_i = 0;
  logic dgrade_valid_i = 0, dgrade_dirty_i = 0;
  logic tx_active_o, commit_o, abort_o, fwd_ok_o;
  logic [2:0] abort_cause_o;
  logic [LINES-1:0] rd_set_o, wr_set_o, inval_mask_o;

  htm_conflict_tracker i_htm_conflict_tracker (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [LINES-1:0] m_rd = '0, m_wr = '0;
  int m_dep = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_cause(bit act, bit x, bit shit, bit ehit, bit dhit, bit ovf);
    if (!act) return 0;
    if (x) return 1;
    if (shit) return 2;
    if (ehit) return 3;
    if (dhit) return 4;
    if (ovf) return 5;
    return 0;
  endfunction

  task automatic step(bit b, bit e, bit x, bit av, bit as, int ai,
                      bit sv, int si, bit ev, int ei, bit ed,
                      bit dv, int di, bit dd, string req);
    logic [LINES-1:0] txl, e_inval;
    bit act, shit, ehit, dhit, ovf, ab, cm, fwd;
    int c;
    tx_begin_i = b; tx_end_i = e; tx_abort_i = x;
    acc_valid_i = av; acc_store_i = as; acc_idx_i = IDX_W'(ai);
    snp_valid_i = sv; snp_idx_i = IDX_W'(si);
    evict_valid_i = ev; evict_idx_i = IDX_W'(ei); evict_dirty_i = ed;
    dgrade_valid_i = dv; dgrade_idx_i = IDX_W'(di); dgrade_dirty_i = dd;
    act  = (m_dep != 0);
    txl  = m_rd | m_wr;
    shit = act && sv && txl[si];
    ehit = act && ev && ed && txl[ei];
    dhit = act && dv && dd && txl[di];
    ovf  = act && b && !e && (m_dep == 15);
    c    = exp_cause(act, x, shit, ehit, dhit, ovf);
    ab   = (c != 0);
    cm   = !ab && e && !b && (m_dep == 1);
    fwd  = (sv || dv) && !shit && !dhit;
    e_inval = ab ? m_wr : '0;
    #1;
    chk({req, "/R4 fwd_ok"}, 32'(fwd_ok_o), 32'(fwd));
    if (ab || cm) begin
      m_rd = '0; m_wr = '0; m_dep = 0;
    end else begin
      if (act && av) begin
        if (as) m_wr[ai] = 1'b1; else m_rd[ai] = 1'b1;
      end
      if (b && !e) m_dep++;
      else if (e && !b && act) m_dep--;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk({req, "/R2 commit"}, 32'(commit_o), 32'(cm));
    chk({req, "/R12 abort"}, 32'(abort_o), 32'(ab));
    chk({req, "/R12 cause"}, 32'(abort_cause_o), 32'(c));
    chk({req, "/R9 inval"}, 32'(inval_mask_o), 32'(e_inval));
    chk({req, "/R2 active"}, 32'(tx_active_o), 32'(m_dep != 0));
    chk({req, "/R3 rd_set"}, 32'(rd_set_o), 32'(m_rd));
    chk({req, "/R3 wr_set"}, 32'(wr_set_o), 32'(m_wr));
  endtask

  // short-hands
  task automatic idle(string r);          step(0,0,0, 0,0,0, 0,0, 0,0,0, 0,0,0, r); endtask
  task automatic tbeg(string r);          step(1,0,0, 0,0,0, 0,0, 0,0,0, 0,0,0, r); endtask
  task automatic tend(string r);          step(0,1,0, 0,0,0, 0,0, 0,0,0, 0,0,0, r); endtask
  task automatic ld(int i, string r);     step(0,0,0, 1,0,i, 0,0, 0,0,0, 0,0,0, r); endtask
  task automatic st(int i, string r);     step(0,0,0, 1,1,i, 0,0, 0,0,0, 0,0,0, r); endtask
  task automatic snp(int i, string r);    step(0,0,0, 0,0,0, 1,i, 0,0,0, 0,0,0, r); endtask
  task automatic evc(int i, bit d, string r); step(0,0,0, 0,0,0, 0,0, 1,i,d, 0,0,0, r); endtask
  task automatic dgr(int i, bit d, string r); step(0,0,0, 0,0,0, 0,0, 0,0,0, 1,i,d, r); endtask

  initial begin
    #(4*200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 active", 32'(tx_active_o), 0);
    chk("R1 commit", 32'(commit_o), 0);
    chk("R1 abort", 32'(abort_o), 0);
    chk("R1 cause", 32'(abort_cause_o), 0);
    chk("R1 sets", 32'(rd_set_o | wr_set_o | inval_mask_o), 0);
    rst_ni = 1'b1;
    idle("R1");
    // R3: accesses while idle set nothing
    ld(3, "R3"); st(4, "R3");
    // R2/R8: nested commit
    tbeg("R2"); ld(3, "R3"); st(5, "R3"); tbeg("R2");
    tend("R2"); st(7, "R3"); tend("R8");
    // R11: end while idle
    tend("R11");
    // R4 and R9
    tbeg("R4"); st(2, "R4"); ld(4, "R4"); snp(9, "R4"); snp(4, "R9");
    // R5
    tbeg("R5"); st(6, "R5"); evc(6, 0, "R5"); evc(8, 1, "R5"); evc(6, 1, "R5");
    // R6
    tbeg("R6"); ld(1, "R6"); dgr(1, 0, "R6"); dgr(1, 1, "R6");
    // R7
    step(0,0,1, 0,0,0, 0,0, 0,0,0, 0,0,0, "R7");
    tbeg("R7"); tbeg("R7"); st(0, "R7");
    step(0,0,1, 0,0,0, 0,0, 0,0,0, 0,0,0, "R7");
    // R10 / R13: overflow
    for (int k = 0; k < 15; k++) tbeg("R10");
    step(1,1,0, 0,0,0, 0,0, 0,0,0, 0,0,0, "R13");
    ld(11, "R10");
    tbeg("R10");
    // R12: conflict with final end, and cause priority
    tbeg("R12"); ld(0, "R12");
    step(0,1,0, 0,0,0, 1,0, 0,0,0, 0,0,0, "R12");
    tbeg("R12"); st(9, "R12");
    step(0,0,1, 0,0,0, 1,9, 1,9,1, 0,0,0, "R12");
    tbeg("R12"); st(9, "R12");
    step(0,0,0, 0,0,0, 1,9, 1,9,1, 1,9,1, "R12");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit b, e, x, av, sv, ev, dv;
      b  = ($urandom % 100) < 12;
      e  = ($urandom % 100) < 10;
      x  = ($urandom % 200) < 2;
      av = ($urandom % 100) < 50;
      sv = ($urandom % 100) < 4;
      ev = ($urandom % 100) < 4;
      dv = ($urandom % 100) < 4;
      step(b, e, x, av, 1'($urandom), int'($urandom % 16),
           sv, int'($urandom % 16), ev, int'($urandom % 16), 1'($urandom),
           dv, int'($urandom % 16), 1'($urandom), "RND");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule